// File: doc/BRIEF.md
# Variable-Length Bytecode Instruction Decoder

This block turns the bytes at the program counter of a register-based bytecode machine into one decoded instruction. The fetch stage presents a 10-byte window that starts at the opcode, with a valid strobe. One clock later, the decoder returns a registered bundle. The bundle holds the opcode's category, its operation index, up to three 4-bit register indices, a 64-bit immediate, the instruction length in bytes (1, 2, 3 or 10), and a flag that marks an undefined opcode.

The fetch stage uses the returned length to advance the program counter. The execute stage uses the category and operation to select its action. Register indices are packed as nibbles, and the bytes they come from depend on the operand layout of each opcode. The decoder zeroes any field that the current layout does not define. Downstream logic can therefore compare fields without knowing the layout.

The block does not fetch bytes from memory, execute instructions or charge gas.

Top module: `vmdec_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. While `out_valid` is low, every other output is zero.
- R2: The 43 defined opcodes are: 0x00-0x05, 0x0F, 0x10-0x15, 0x20-0x25, 0x30-0x36, 0x40-0x45, 0x50, 0x51, 0x70, 0x71, 0x80-0x85 and 0xF0. For any other opcode byte, `out_invalid` is 1 and every other field except `out_valid` is 0.
- R3: `out_cat` encodes the opcode's high nibble as follows: 0x0 gives 0, 0x1 gives 1, 0x2 gives 2, 0x3 gives 3, 0x4 gives 4, 0x5 gives 5, 0x7 gives 6, 0x8 gives 7 and 0xF gives 8.
- R4: For a defined opcode, `out_op` equals the low nibble of the opcode.
- R5: Opcodes 0x00, 0x01 and 0x05 have length 1 and no register or immediate fields.
- R6: Opcodes 0x02, 0x23, 0x44, 0x80-0x85 and 0xF0 have length 2 and use the one-register layout. `out_ra` is bits [7:4] of byte 1, and `out_rb`, `out_rc` and `out_imm` are 0.
- R7: Opcodes 0x36, 0x40-0x43, 0x50, 0x51 and 0x71 have length 2 and use the two-register layout. `out_ra` is byte 1 bits [7:4], `out_rb` is byte 1 bits [3:0], and `out_rc` is 0.
- R8: Opcodes 0x04, 0x0F and 0x15 are defined but use the fallback: length 2 with the two-register layout of R7.
- R9: Opcodes 0x03, 0x10-0x14, 0x20-0x22, 0x24, 0x25, 0x30-0x35 and 0x45 have length 3. `out_ra` is byte 1 [7:4], `out_rb` is byte 1 [3:0] and `out_rc` is byte 2 [7:4]. Byte 2 [3:0] has no effect on any output.
- R10: Opcode 0x70 has length 10. `out_ra` is byte 1 [7:4], and `out_imm` is bytes 2..9 with byte 2 as the least significant. The immediate is zero for every other opcode.
- R11: Byte k of the window sits at `in_win[8k+7:8k]`. Byte 0 is the opcode. Bytes beyond an instruction's length have no effect on its outputs.
- R12: After reset, all outputs are zero until the first strobe has been registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Window strobe |
| in_win | input | 80 | Fetch window; byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Decoded bundle valid |
| out_invalid | output | 1 | Opcode is undefined |
| out_cat | output | 4 | Category code |
| out_op | output | 4 | Operation index within category |
| out_ra | output | 4 | First register (destination or sole) |
| out_rb | output | 4 | Second register |
| out_rc | output | 4 | Third register |
| out_len | output | 4 | Instruction length in bytes |
| out_imm | output | 64 | 64-bit immediate |

## Verification
Every result passes through one register. It is therefore due on the first rising edge after the strobe cycle, and it falls back to zero one edge after the strobe drops. The bench drives each window on a falling edge and reads the bundle on the next falling edge, half a period after that first rising edge. It then drops the strobe and reads the idle outputs on the following falling edge. The bench sweeps all 256 opcode values under three operand-byte patterns, including all-ones bytes. The all-ones pattern shows that padding nibbles and bytes beyond the instruction's length do not leak into the outputs.

// File: rtl/vmdec_pkg.sv
package vmdec_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIN_BYTES = 10;
    localparam int WIN_W     = WIN_BYTES * BYTE_W;
    localparam int IDX_W     = 4;
    localparam int IMM_BYTES = 8;
    localparam int IMM_W     = IMM_BYTES * BYTE_W;
    localparam int IMM_FIRST = 2;
    localparam int LEN_W     = 4;
    localparam int CAT_W     = 4;

    typedef enum logic [2:0] {
        FMT_BARE,
        FMT_ONE,
        FMT_TWO,
        FMT_THREE,
        FMT_WIDE
    } fmt_e;

    typedef struct packed {
        logic             vld;
        logic             bad;
        logic [CAT_W-1:0] cat;
        logic [3:0]       op;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [IDX_W-1:0] rc;
        logic [LEN_W-1:0] len;
        logic [IMM_W-1:0] imm;
    } dec_t;

endpackage

// File: rtl/vmdec_classify.sv
module vmdec_classify
    import vmdec_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    output logic              known,
    output fmt_e              fmt,
    output logic [CAT_W-1:0]  cat,
    output logic [LEN_W-1:0]  len
);

    // Opcode table: operand layout of each defined opcode
    always_comb begin
        known = 1'b1;
        fmt   = FMT_BARE;
        case (opc) inside
            8'h00, 8'h01, 8'h05:                         fmt = FMT_BARE;
            8'h02, 8'h23, 8'h44, 8'hF0, [8'h80:8'h85]:   fmt = FMT_ONE;
            8'h36, [8'h40:8'h43], 8'h50, 8'h51, 8'h71,
            8'h04, 8'h0F, 8'h15:                         fmt = FMT_TWO;
            8'h03, [8'h10:8'h14], [8'h20:8'h22], 8'h24,
            8'h25, [8'h30:8'h35], 8'h45:                 fmt = FMT_THREE;
            8'h70:                                       fmt = FMT_WIDE;
            default:                                     known = 1'b0;
        endcase
    end

    // Length follows from the layout
    always_comb begin
        case (fmt)
            FMT_BARE:  len = LEN_W'(1);
            FMT_THREE: len = LEN_W'(3);
            FMT_WIDE:  len = LEN_W'(IMM_FIRST + IMM_BYTES);
            default:   len = LEN_W'(2);
        endcase
    end

    // Category code from the opcode range
    always_comb begin
        case (opc[7:4])
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: cat = CAT_W'(opc[7:4]);
            4'h7:    cat = CAT_W'(6);
            4'h8:    cat = CAT_W'(7);
            4'hF:    cat = CAT_W'(8);
            default: cat = '0;
        endcase
    end

endmodule

// File: rtl/vmdec_fields.sv
module vmdec_fields
    import vmdec_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  fmt_e             fmt,
    output logic [IDX_W-1:0] ra,
    output logic [IDX_W-1:0] rb,
    output logic [IDX_W-1:0] rc,
    output logic [IMM_W-1:0] imm
);

    localparam int B1 = 1 * BYTE_W;
    localparam int B2 = 2 * BYTE_W;

    logic [IMM_W-1:0] imm_raw;

    // Immediate: little-endian bytes starting at IMM_FIRST
    for (genvar g = 0; g < IMM_BYTES; g++) begin : g_imm
        assign imm_raw[g*BYTE_W +: BYTE_W] = win[(IMM_FIRST+g)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        ra  = '0;
        rb  = '0;
        rc  = '0;
        imm = '0;
        case (fmt)
            FMT_ONE: ra = win[B1+4 +: IDX_W];
            FMT_TWO: begin
                ra = win[B1+4 +: IDX_W];
                rb = win[B1   +: IDX_W];
            end
            FMT_THREE: begin
                ra = win[B1+4 +: IDX_W];
                rb = win[B1   +: IDX_W];
                rc = win[B2+4 +: IDX_W];
            end
            FMT_WIDE: begin
                ra  = win[B1+4 +: IDX_W];
                imm = imm_raw;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vmdec_top.sv
module vmdec_top
    import vmdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIN_W-1:0] in_win,
    output logic             out_valid,
    output logic             out_invalid,
    output logic [CAT_W-1:0] out_cat,
    output logic [3:0]       out_op,
    output logic [IDX_W-1:0] out_ra,
    output logic [IDX_W-1:0] out_rb,
    output logic [IDX_W-1:0] out_rc,
    output logic [LEN_W-1:0] out_len,
    output logic [IMM_W-1:0] out_imm
);

    logic             known;
    fmt_e             fmt;
    logic [CAT_W-1:0] cat;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] ra, rb, rc;
    logic [IMM_W-1:0] imm;
    dec_t             dec_d, dec_q;

    vmdec_classify u_cls (
        .opc   (in_win[BYTE_W-1:0]),
        .known (known),
        .fmt   (fmt),
        .cat   (cat),
        .len   (len)
    );

    vmdec_fields u_fld (
        .win (in_win),
        .fmt (fmt),
        .ra  (ra),
        .rb  (rb),
        .rc  (rc),
        .imm (imm)
    );

    always_comb begin
        dec_d     = '0;
        dec_d.vld = in_valid;
        if (in_valid) begin
            if (known) begin
                dec_d.cat = cat;
                dec_d.op  = in_win[3:0];
                dec_d.ra  = ra;
                dec_d.rb  = rb;
                dec_d.rc  = rc;
                dec_d.len = len;
                dec_d.imm = imm;
            end else begin
                dec_d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid   = dec_q.vld;
    assign out_invalid = dec_q.bad;
    assign out_cat     = dec_q.cat;
    assign out_op      = dec_q.op;
    assign out_ra      = dec_q.ra;
    assign out_rb      = dec_q.rb;
    assign out_rc      = dec_q.rc;
    assign out_len     = dec_q.len;
    assign out_imm     = dec_q.imm;

    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_invalid && out_len == '0 && out_imm == '0 && out_ra == '0));

    // R2
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_cat == '0 && out_op == '0 && out_len == '0 &&
                         out_ra == '0 && out_rb == '0 && out_rc == '0 && out_imm == '0));

    // R5
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |->
            (out_len == 4'd1 || out_len == 4'd2 || out_len == 4'd3 || out_len == 4'd10));

    // R10
    imm_wide_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_imm != '0) |-> (out_len == 4'd10));

    // R9
    rc_three_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rc != '0) |-> (out_len == 4'd3));

endmodule

// File: tb/tb_vmdec_top.sv
`timescale 1ns/1ps
module tb_vmdec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [79:0] in_win = '0;
    logic        out_valid, out_invalid;
    logic [3:0]  out_cat, out_op, out_ra, out_rb, out_rc, out_len;
    logic [63:0] out_imm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vmdec_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win),
        .out_valid(out_valid), .out_invalid(out_invalid), .out_cat(out_cat),
        .out_op(out_op), .out_ra(out_ra), .out_rb(out_rb), .out_rc(out_rc),
        .out_len(out_len), .out_imm(out_imm)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // kind: 0 undefined, 1 bare, 2 one-reg, 3 two-reg, 4 three-reg, 5 wide
    function automatic int kind_of(input logic [7:0] o);
        int hi = int'(o[7:4]);
        int lo = int'(o[3:0]);
        if (o == 8'h70) return 5;
        if (o == 8'h00 || o == 8'h01 || o == 8'h05) return 1;
        if (o == 8'h02 || o == 8'h23 || o == 8'h44 || o == 8'hF0) return 2;
        if (hi == 8 && lo <= 5) return 2;
        if (o == 8'h36 || o == 8'h71 || o == 8'h50 || o == 8'h51) return 3;
        if (hi == 4 && lo <= 3) return 3;
        if (o == 8'h04 || o == 8'h0F || o == 8'h15) return 3;
        if (o == 8'h03 || o == 8'h45) return 4;
        if (hi == 1 && lo <= 4) return 4;
        if (hi == 2 && lo <= 5) return 4;
        if (hi == 3 && lo <= 5) return 4;
        return 0;
    endfunction

    function automatic logic [7:0] pat_byte(input int p, input int k, input logic [7:0] o);
        if (p == 0) return 8'hFF;
        if (p == 1) return 8'h00;
        return 8'((k * 27) + (int'(o) * 7) + 60);
    endfunction

    task automatic run_one(input logic [7:0] o, input int p);
        logic [79:0] w;
        int kd, exp_len, exp_cat;
        logic [3:0] era, erb, erc;
        logic [63:0] eimm;
        string tag;
        w[7:0] = o;
        for (int k = 1; k < 10; k++) w[8*k +: 8] = pat_byte(p, k, o);
        kd = kind_of(o);
        case (kd)
            1: exp_len = 1;
            4: exp_len = 3;
            5: exp_len = 10;
            0: exp_len = 0;
            default: exp_len = 2;
        endcase
        case (o[7:4])
            4'h7: exp_cat = 6;
            4'h8: exp_cat = 7;
            4'hF: exp_cat = 8;
            default: exp_cat = int'(o[7:4]);
        endcase
        if (kd == 0) exp_cat = 0;
        era  = (kd >= 2) ? w[15:12] : 4'h0;
        erb  = (kd == 3 || kd == 4) ? w[11:8] : 4'h0;
        erc  = (kd == 4) ? w[23:20] : 4'h0;
        eimm = '0;
        for (int b = 0; b < 8; b++) eimm = eimm | (64'(w[8*(2+b) +: 8]) << (8*b));
        if (kd != 5) eimm = '0;
        case (kd)
            1: tag = "R5";
            2: tag = "R6";
            3: tag = (o == 8'h04 || o == 8'h0F || o == 8'h15) ? "R8" : "R7";
            4: tag = "R9";
            5: tag = "R10";
            default: tag = "R2";
        endcase

        @(negedge clk);
        in_valid = 1'b1;
        in_win   = w;
        @(negedge clk);
        chk("R1 valid", 64'(out_valid), 64'd1);
        chk("R2 invalid flag", 64'(out_invalid), 64'(kd == 0));
        chk("R3 category", 64'(out_cat), 64'(exp_cat));
        chk("R4 operation", 64'(out_op), (kd == 0) ? 64'd0 : 64'(o[3:0]));
        chk({tag, " length"}, 64'(out_len), 64'(exp_len));
        chk({tag, " ra"}, 64'(out_ra), 64'(era));
        chk({tag, " rb"}, 64'(out_rb), 64'(erb));
        chk({tag, " rc R11"}, 64'(out_rc), 64'(erc));
        chk({tag, " imm R11"}, out_imm, eimm);
        in_valid = 1'b0;
        in_win   = '1;
    endtask

    initial begin
        in_win = '1;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 valid", 64'(out_valid), 64'd0);
        chk("R12 len", 64'(out_len), 64'd0);
        chk("R12 imm", out_imm, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after release", 64'(out_valid) | 64'(out_invalid) | 64'(out_ra), 64'd0);

        for (int p = 0; p < 3; p++)
            for (int o = 0; o < 256; o++) run_one(8'(o), p);

        // R1: idle after strobe drops
        @(negedge clk);
        chk("R1 idle valid", 64'(out_valid), 64'd0);
        chk("R1 idle fields", 64'(out_len) | 64'(out_cat) | 64'(out_ra) | out_imm, 64'd0);

        // R10: known immediate, byte 2 least significant
        @(negedge clk);
        in_valid = 1'b1;
        in_win   = {64'h0102030405060708, 8'h30, 8'h70};
        @(negedge clk);
        chk("R10 imm order", out_imm, 64'h0102030405060708);
        chk("R10 ra", 64'(out_ra), 64'd3);
        in_valid = 1'b0;

        // R9: add 0x10, byte1 0x20 byte2 0x1F -> ra 2 rb 0 rc 1
        @(negedge clk);
        in_valid = 1'b1;
        in_win   = {56'hFF_FFFF_FFFF_FFFF, 8'h1F, 8'h20, 8'h10};
        @(negedge clk);
        chk("R9 padding", {out_ra, out_rb, out_rc}, 12'h201);
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule